// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block drives the bit clock and the frame clock of a stereo audio serial port when the port is the interface master. It runs from one master clock. An optional predivide halves the master clock rate before any other logic uses it. A two-bit speed code then sets the division, so that the frame clock equals the sample rate and the bit clock runs at 64 times that rate. Each channel half-frame therefore carries 32 bit-clock periods.

Both clocks come from a single free-running counter. A frame-clock edge always falls on a bit-clock falling edge. The left channel is the low half of the frame.

Any change to the configuration restarts the frame from the start of the left channel. A reserved speed code, or a predivide request while the port is a slave, raises an error flag and holds the clocks low. In slave mode the output-enable goes low, so the pads can be left to an external clock source.

Top module: `aud_clk_gen`

## Requirements
- R1: With `mdiv_i`=1 every counter step takes two master-clock cycles, so both output periods double. With `mdiv_i`=0 the counter steps on every master-clock cycle.
- R2: Speed code 00 (single) makes `lrck_o` toggle every 128 counter steps, a frame of 256, and makes `sclk_o` a period of 4 steps.
- R3: Speed code 01 (double) gives a frame of 128 steps and an `sclk_o` period of 2 steps. Speed code 10 (quad) gives a frame of 64 steps and an `sclk_o` period of 1 step. Every speed has 64 `sclk_o` periods per frame.
- R4: `lrck_o` is low for the first (left) half-frame. Each `lrck_o` transition that is not caused by a restart coincides with a falling edge of `sclk_o`.
- R5: Speed code 11 is reserved. It sets `mode_err_o` and holds `sclk_o` and `lrck_o` low.
- R6: With `master_i`=0, `out_en_o` is low and both clocks are held low. If `mdiv_i`=1 in this state, `mode_err_o` is also set.
- R7: A change of `speed_i`, `mdiv_i` or `master_i` takes effect at the next clock edge. That edge restarts the frame, so right after it `lrck_o` is low and the counter is at 0.
- R8: In quad speed with `mdiv_i`=0, `sclk_o` is the inverted master clock, gated without glitches. It is low while `clk_i` is high and high while `clk_i` is low.
- R9: While `rst_ni` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdiv_i | input | 1 | Predivide: 1 halves the master clock |
| speed_i | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 reserved |
| master_i | input | 1 | 1 = port is interface master |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock, low for left |
| out_en_o | output | 1 | Pad drive enable for both clocks |
| mode_err_o | output | 1 | Illegal configuration flag |

## Verification
A configuration change and a frame-clock transition can land on the same master-clock edge. In that case the restart must win: `lrck_o` stays low and the counter starts again at zero, instead of entering the right half.

A directed case runs single speed up to the step just before the half-frame boundary and then changes the mode on that boundary edge. The random phase, with configuration run lengths drawn from `$urandom`, lands further changes on arbitrary counter phases. A bench model that restarts its step count on every configuration change judges both kinds of case, sample by sample, in both phases of the master clock.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  typedef struct packed {
    logic   master;
    logic   mdiv;
    speed_e speed;
  } cfg_t;

  localparam cfg_t CFG_RST = '{master: 1'b0, mdiv: 1'b0, speed: SPD_SINGLE};

  function automatic logic cfg_bad(cfg_t c);
    return (c.speed == SPD_RSVD) || (!c.master && c.mdiv);
  endfunction

  function automatic logic cfg_bypass(cfg_t c);
    return c.master && !cfg_bad(c) && (c.speed == SPD_QUAD) && !c.mdiv;
  endfunction

endpackage

// File: rtl/aud_clk_cfg.sv
module aud_clk_cfg
  import aud_clk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_i,
  output cfg_t cfg_o,
  output logic restart_o,
  output logic run_o,
  output logic err_o,
  output logic byp_o
);

  cfg_t cfg_q;
  logic byp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      byp_q <= 1'b0;
    end else begin
      cfg_q <= cfg_i;
      // updates while the inverted clock is low: no glitch on the gated output
      byp_q <= cfg_bypass(cfg_i);
    end
  end

  assign restart_o = (cfg_i != cfg_q);
  assign err_o     = cfg_bad(cfg_q);
  assign run_o     = cfg_q.master && !err_o;
  assign byp_o     = byp_q;
  assign cfg_o     = cfg_q;

endmodule

// File: rtl/aud_clk_cnt.sv
module aud_clk_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             mdiv_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ph_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;
  logic             step;

  // predivide as a step enable: one step per two master cycles
  assign step = !mdiv_i || ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (restart_i || !run_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      ph_q <= mdiv_i ? !ph_q : 1'b0;
      if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ph_o  = ph_q;

endmodule

// File: rtl/aud_clk_sel.sv
module aud_clk_sel
  import aud_clk_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned BCLK_W = 6
) (
  input  logic             clk_i,
  input  cfg_t             cfg_i,
  input  logic             byp_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ph_i,
  output logic             sclk_o,
  output logic             lrck_o
);

  localparam int NSPD = 4;

  logic [NSPD-1:0] lr_tap;
  logic [NSPD-1:0] bc_tap;
  logic            bc_reg;

  for (genvar s = 0; s < NSPD - 1; s++) begin : g_tap
    assign lr_tap[s] = cnt_i[CNT_W-1-s];
    if (int'(CNT_W) - int'(BCLK_W) - 1 - s >= 0) begin : g_cnt
      assign bc_tap[s] = cnt_i[CNT_W-BCLK_W-1-s];
    end else begin : g_ph
      assign bc_tap[s] = ph_i;
    end
  end
  assign lr_tap[NSPD-1] = 1'b0;
  assign bc_tap[NSPD-1] = 1'b0;

  assign bc_reg = (cfg_i.speed == SPD_QUAD && !cfg_i.mdiv) ? 1'b0 : bc_tap[cfg_i.speed];
  assign sclk_o = bc_reg | (~clk_i & byp_i);
  assign lrck_o = lr_tap[cfg_i.speed];

endmodule

// File: rtl/aud_clk_gen.sv
module aud_clk_gen
  import aud_clk_pkg::*;
#(
  parameter int unsigned FRAME_DIV  = 256,
  parameter int unsigned BCLK_FRAME = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mdiv_i,
  input  logic [1:0] speed_i,
  input  logic       master_i,
  output logic       sclk_o,
  output logic       lrck_o,
  output logic       out_en_o,
  output logic       mode_err_o
);

  localparam int unsigned CNT_W  = $clog2(FRAME_DIV);
  localparam int unsigned BCLK_W = $clog2(BCLK_FRAME);

  cfg_t             cfg_d, cfg_q;
  logic             restart, run, byp, ph;
  logic [CNT_W-1:0] cnt;

  assign cfg_d = '{master: master_i, mdiv: mdiv_i, speed: speed_e'(speed_i)};

  aud_clk_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_d),
    .cfg_o     (cfg_q),
    .restart_o (restart),
    .run_o     (run),
    .err_o     (mode_err_o),
    .byp_o     (byp)
  );

  aud_clk_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (restart),
    .mdiv_i    (cfg_q.mdiv),
    .cnt_o     (cnt),
    .ph_o      (ph)
  );

  aud_clk_sel #(.CNT_W(CNT_W), .BCLK_W(BCLK_W)) u_sel (
    .clk_i  (clk_i),
    .cfg_i  (cfg_q),
    .byp_i  (byp),
    .cnt_i  (cnt),
    .ph_i   (ph),
    .sclk_o (sclk_o),
    .lrck_o (lrck_o)
  );

  assign out_en_o = cfg_q.master;

endmodule

// File: rtl/aud_clk_gen_chk.sv
module aud_clk_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mdiv_i,
  input logic [1:0] speed_i,
  input logic       master_i,
  input logic       sclk_o,
  input logic       lrck_o,
  input logic       out_en_o,
  input logic       mode_err_o
);

  p_reserved_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(speed_i) == 2'b11 |-> mode_err_o && !lrck_o);

  p_err_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_err_o |-> !lrck_o && !sclk_o);

  p_slave_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(master_i) |-> !out_en_o && !lrck_o && !sclk_o);

  p_slave_mdiv_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(master_i) && $past(mdiv_i) |-> mode_err_o);

  p_restart_left_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$stable(speed_i) |=> !lrck_o);

  p_lr_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lrck_o) && !($past(speed_i) == 2'b10 && !$past(mdiv_i)) |-> $fell(sclk_o));

endmodule

bind aud_clk_gen aud_clk_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mdiv_i     (mdiv_i),
  .speed_i    (speed_i),
  .master_i   (master_i),
  .sclk_o     (sclk_o),
  .lrck_o     (lrck_o),
  .out_en_o   (out_en_o),
  .mode_err_o (mode_err_o)
);

// File: tb/tb_aud_clk_gen.sv
module tb_aud_clk_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mdiv = 1'b0;
  logic [1:0] speed = 2'b00;
  logic       master = 1'b0;
  logic       sclk, lrck, oe, err;

  int n_chk = 0;
  int n_bad = 0;
  int n = 0;
  logic [3:0] cur = 4'b0000;   // {master, mdiv, speed} held by the design
  logic restarted = 1'b0;
  logic prev_lr = 1'b0, prev_sclk_lo = 1'b0;

  always #10 clk = ~clk;

  aud_clk_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .mdiv_i(mdiv), .speed_i(speed), .master_i(master),
    .sclk_o(sclk), .lrck_o(lrck), .out_en_o(oe), .mode_err_o(err)
  );

  function automatic logic [3:0] exp_f(int k, logic [1:0] sp, logic md, logic ms, logic low);
    logic e, r, l, s;
    int c;
    e = (sp == 2'b11) || (!ms && md);
    r = ms && !e;
    c = (md ? k / 2 : k) % 256;
    l = 1'b0; s = 1'b0;
    if (r) begin
      l = c[7 - sp];
      case (sp)
        2'b00: s = c[1];
        2'b01: s = c[0];
        default: s = md ? k[0] : low;
      endcase
    end
    return {e, ms, l, s};
  endfunction

  function automatic string tag_f(logic [1:0] sp, logic md, logic ms, int k);
    if (sp == 2'b11) return "R5";
    if (!ms) return "R6";
    if (k < 4) return "R7";
    if (sp == 2'b10 && !md) return "R8";
    if (md) return "R1";
    if (sp == 2'b00) return "R2";
    return "R3";
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: n=%0d cfg=%b got %b exp %b", tag, n, cur, got, exp);
    end
  endtask

  task automatic step();
    logic [3:0] hi, lo;
    @(posedge clk);
    if ({master, mdiv, speed} != cur) begin
      cur = {master, mdiv, speed}; n = 0; restarted = 1'b1;
    end else begin
      n++; restarted = 1'b0;
    end
    #5;
    hi = {err, oe, lrck, sclk};
    check(tag_f(cur[1:0], cur[2], cur[3], n), hi, exp_f(n, cur[1:0], cur[2], cur[3], 1'b0));
    #10;
    lo = {err, oe, lrck, sclk};
    check(tag_f(cur[1:0], cur[2], cur[3], n), lo, exp_f(n, cur[1:0], cur[2], cur[3], 1'b1));
    // R4: non-restart frame edge sits on a bit-clock fall
    if (!restarted && lrck !== prev_lr)
      check("R4", {prev_sclk_lo, hi[0]}, 2'b10);
    prev_lr = lrck;
    prev_sclk_lo = lo[0];
  endtask

  task automatic apply(logic [1:0] sp, logic md, logic ms, int len);
    speed = sp; mdiv = md; master = ms;
    for (int i = 0; i < len; i++) step();
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    speed = 2'b10; mdiv = 1'b0; master = 1'b1;
    repeat (3) @(posedge clk);
    #15;
    check("R9", {err, oe, lrck, sclk}, 4'b0000);
    rst_n = 1'b1;
    cur = 4'b0000; n = 0;

    for (int sp = 0; sp < 3; sp++)
      for (int md = 0; md < 2; md++)
        apply(sp[1:0], md[0], 1'b1, 1100);

    apply(2'b11, 1'b0, 1'b1, 20);   // R5
    apply(2'b00, 1'b1, 1'b0, 20);   // R6 with error
    apply(2'b01, 1'b0, 1'b0, 20);   // R6 plain slave

    // R7: change lands on the edge where lrck would rise
    apply(2'b00, 1'b0, 1'b1, 128);
    apply(2'b01, 1'b0, 1'b1, 300);
    apply(2'b00, 1'b1, 1'b1, 255);
    apply(2'b00, 1'b0, 1'b1, 10);

    for (int t = 0; t < 60; t++) begin
      logic [1:0] sp;
      logic md, ms;
      sp = 2'($urandom % 4);
      md = 1'($urandom % 2);
      ms = ($urandom % 4) != 0;
      apply(sp, md, ms, 1 + int'($urandom % 400));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule